// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates one 32-bit virtual address at a time for a classic two-level paging scheme without physical address extension. A request carries the virtual address, the access kind (read, write or instruction fetch) and whether the access comes from user privilege. The walker fetches the directory entry and, for a 4 KB mapping, the table entry, through a single-word memory port. It applies the user/supervisor and read/write rules and sets the accessed and dirty flags in memory. It then answers with either a physical address plus the rights a translation cache may record, or a page-fault code.

Configuration is taken live from five inputs: paging enable, supervisor write protect, large-page enable, the directory base frame and an address mask for the 1 MB wrap line. The sequencer has seven named states. IDLE accepts a request. DIR_RD reads the directory entry. DIR_WB writes back the directory entry with its accessed flag set before descending. TBL_RD reads the table entry. LEAF_WB writes back the final entry. DONE and FAULT are one-cycle response states that return to IDLE.

The transitions are as follows. IDLE goes to DIR_RD on a request when paging is on, or straight to DONE when it is off. DIR_RD goes to FAULT (entry absent or rights denied), to LEAF_WB or DONE (large page, depending on whether the entry changed), to DIR_WB (table pointer with accessed clear) or to TBL_RD. DIR_WB goes to TBL_RD. TBL_RD goes to FAULT, LEAF_WB or DONE. LEAF_WB goes to DONE. DONE and FAULT both go to IDLE.

Top module: `pt_walker`

## Requirements
- R1: With paging disabled, a request completes with `done` in the cycle after acceptance, `rsp_paddr` equal to the virtual address, write and execute both granted, and no memory access.
- R2: The first read address is ({cfg_dir_frame, 12'h000} + 4 * vaddr[31:22]) ANDed with `cfg_a20_mask`.
- R3: A directory entry with bit 7 (page size) set while `cfg_pse` is 1 maps a 4 MB page: paddr = {entry[31:22], vaddr[21:0]}, and no table entry is read; with `cfg_pse` 0 bit 7 is ignored and the entry points to a table.
- R4: For a 4 KB mapping the second read address is ({entry[31:12], 12'h000} + 4 * vaddr[21:12]) ANDed with the mask, paddr = {table_entry[31:12], vaddr[11:0]}, and the user (bit 2) and writable (bit 1) rights are the AND of both levels.
- R5: A user access (`req_user` 1) faults when the combined user right is 0, or when it is a write (`req_acc` 2'b01) and the combined writable right is 0; reads are 2'b00 and fetches 2'b10 and neither counts as a write.
- R6: A supervisor write to a non-writable page faults only when `cfg_wp` is 1; supervisor reads and fetches never fault on rights.
- R7: An entry with bit 0 (present) clear produces `fault` with `rsp_fault_code` = {user, write, 1'b0}.
- R8: A rights violation produces `fault` with `rsp_fault_code` = {user, write, 1'b1}.
- R9: On the way down, a directory entry pointing to a table with bit 5 (accessed) clear is written back with bit 5 set, even if the table level then faults. On success the final entry is written back with bit 5 set and, for writes, bit 6 (dirty) set. A write happens only when the value changed, and a faulting final entry is never written.
- R10: `rsp_wr_ok` is 1 only when the final entry (after update) has bit 6 set and either the combined writable right is 1, or the access is supervisor and `cfg_wp` is 0; `rsp_exec_ok` is 1 on every successful walk.
- R11: Bits [31:22] (4 MB) or [31:12] (4 KB) of the physical frame are ANDed with `cfg_a20_mask`.
- R12: `mem_req` with its address, direction and data stays unchanged until `mem_ack`; `done` and `fault` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken only while `busy` is 0) |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| req_user | input | 1 | 1 for user privilege |
| cfg_pg | input | 1 | Paging enable |
| cfg_wp | input | 1 | Supervisor write protect |
| cfg_pse | input | 1 | Large (4 MB) page enable |
| cfg_dir_frame | input | 20 | Directory base frame (address bits 31:12) |
| cfg_a20_mask | input | 32 | Physical address mask |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write access |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Entry value read (valid with `mem_ack`) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Successful translation pulse |
| fault | output | 1 | Page fault pulse |
| rsp_paddr | output | 32 | Physical address (valid with `done`) |
| rsp_wr_ok | output | 1 | Write right to record |
| rsp_exec_ok | output | 1 | Execute right to record |
| rsp_fault_code | output | 3 | {user, write, rights-violation} (valid with `fault`) |

## Verification
The bench sweeps every combination of directory flag bits against access kind, privilege, write protect and large-page enable. It also sweeps table flag bits against both directory rights, and varies the memory latency from walk to walk. A walker that skipped the large-page enable would take a 4 MB path with the enable off and never read the table. One that treated supervisor writes like user writes would fault with write protect off. One that granted write rights from the writable bit alone would report them on clean pages. Write traffic is counted per walk, so a walker that rewrites unchanged entries, forgets the directory accessed flag before a table fault, or writes a faulting entry shows up as a wrong count or a wrong memory word. The mask cases place bit 20 in the directory base and the frame, which exposes an entry address or frame that misses the mask.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
    localparam int unsigned AW        = 32;
    localparam int unsigned OFF_W     = 12;
    localparam int unsigned IDX_W     = 10;
    localparam int unsigned FRAME_W   = AW - OFF_W;
    localparam int unsigned BIG_OFF_W = OFF_W + IDX_W;
    localparam int unsigned BIG_W     = AW - BIG_OFF_W;
    localparam int unsigned CODE_W    = 3;

    localparam int unsigned ENT_P  = 0;
    localparam int unsigned ENT_RW = 1;
    localparam int unsigned ENT_US = 2;
    localparam int unsigned ENT_A  = 5;
    localparam int unsigned ENT_D  = 6;
    localparam int unsigned ENT_PS = 7;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10
    } acc_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_RD,
        S_DIR_WB,
        S_TBL_RD,
        S_LEAF_WB,
        S_DONE,
        S_FAULT
    } walk_st_e;
endpackage

// File: rtl/ptw_addr_gen.sv
`timescale 1ns/1ps
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [FRAME_W-1:0] root_frame,
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic [FRAME_W-1:0] leaf_frame,
    input  logic [AW-1:0]      a20_mask,
    input  logic [AW-1:0]      vaddr,
    output logic [AW-1:0]      dir_addr,
    output logic [AW-1:0]      tbl_addr,
    output logic [AW-1:0]      big_pa,
    output logic [AW-1:0]      small_pa
);
    localparam int unsigned PAD_W = AW - IDX_W - 2;

    logic [AW-1:0] dir_sum;
    logic [AW-1:0] tbl_sum;

    always_comb begin
        dir_sum  = {root_frame, {OFF_W{1'b0}}}
                 + {{PAD_W{1'b0}}, vaddr[AW-1:BIG_OFF_W], 2'b00};
        tbl_sum  = {dir_frame, {OFF_W{1'b0}}}
                 + {{PAD_W{1'b0}}, vaddr[BIG_OFF_W-1:OFF_W], 2'b00};
        dir_addr = dir_sum & a20_mask;
        tbl_addr = tbl_sum & a20_mask;
        big_pa   = {leaf_frame[FRAME_W-1:IDX_W] & a20_mask[AW-1:BIG_OFF_W],
                    vaddr[BIG_OFF_W-1:0]};
        small_pa = {leaf_frame & a20_mask[AW-1:OFF_W], vaddr[OFF_W-1:0]};
    end
endmodule

// File: rtl/ptw_rights.sv
`timescale 1ns/1ps
module ptw_rights (
    input  logic user_ok,
    input  logic rw_ok,
    input  logic dirty,
    input  logic is_write,
    input  logic is_user,
    input  logic wp,
    output logic deny,
    output logic wr_grant
);
    logic wr_blocked;

    always_comb begin
        wr_blocked = is_write && !rw_ok;
        if (is_user) begin
            deny     = !user_ok || wr_blocked;
            wr_grant = dirty && rw_ok;
        end else begin
            deny     = wr_blocked && wp;
            wr_grant = dirty && (rw_ok || !wp);
        end
    end
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
    import ptw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [AW-1:0]       req_vaddr,
    input  logic [1:0]          req_acc,
    input  logic                req_user,
    input  logic                cfg_pg,
    input  logic                cfg_wp,
    input  logic                cfg_pse,
    input  logic [FRAME_W-1:0]  cfg_dir_frame,
    input  logic [AW-1:0]       cfg_a20_mask,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [AW-1:0]       mem_wdata,
    input  logic                mem_ack,
    input  logic [AW-1:0]       mem_rdata,
    output logic                busy,
    output logic                done,
    output logic                fault,
    output logic [AW-1:0]       rsp_paddr,
    output logic                rsp_wr_ok,
    output logic                rsp_exec_ok,
    output logic [CODE_W-1:0]   rsp_fault_code
);
    walk_st_e st, st_nx;

    logic [AW-1:0]      va_q;
    logic               wr_q;
    logic               usr_q;
    logic [FRAME_W-1:0] dir_frame_q;
    logic               dir_us_q;
    logic               dir_rw_q;
    logic [AW-1:0]      wb_addr_q;
    logic [AW-1:0]      wb_data_q;
    logic [AW-1:0]      pa_q;
    logic               wok_q;
    logic               xok_q;
    logic [CODE_W-1:0]  code_q;

    logic [AW-1:0] dir_addr, tbl_addr, big_pa, small_pa;
    logic [AW-1:0] leaf_new;
    logic          leaf_chg;
    logic          ent_present;
    logic          is_big;
    logic          in_tbl;
    logic          comb_us, comb_rw;
    logic          deny, wr_grant;

    ptw_addr_gen u_addr (
        .root_frame (cfg_dir_frame),
        .dir_frame  (dir_frame_q),
        .leaf_frame (mem_rdata[AW-1:OFF_W]),
        .a20_mask   (cfg_a20_mask),
        .vaddr      (va_q),
        .dir_addr   (dir_addr),
        .tbl_addr   (tbl_addr),
        .big_pa     (big_pa),
        .small_pa   (small_pa)
    );

    always_comb begin
        in_tbl      = (st == S_TBL_RD);
        ent_present = mem_rdata[ENT_P];
        is_big      = mem_rdata[ENT_PS] && cfg_pse;
        comb_us     = mem_rdata[ENT_US] && (!in_tbl || dir_us_q);
        comb_rw     = mem_rdata[ENT_RW] && (!in_tbl || dir_rw_q);
        leaf_new    = mem_rdata;
        leaf_new[ENT_A] = 1'b1;
        if (wr_q) leaf_new[ENT_D] = 1'b1;
        leaf_chg    = (leaf_new != mem_rdata);
    end

    ptw_rights u_rights (
        .user_ok  (comb_us),
        .rw_ok    (comb_rw),
        .dirty    (leaf_new[ENT_D]),
        .is_write (wr_q),
        .is_user  (usr_q),
        .wp       (cfg_wp),
        .deny     (deny),
        .wr_grant (wr_grant)
    );

    // next-state decision
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: begin
                if (req_valid) st_nx = cfg_pg ? S_DIR_RD : S_DONE;
            end
            S_DIR_RD: begin
                if (mem_ack) begin
                    if (!ent_present)       st_nx = S_FAULT;
                    else if (is_big)        st_nx = deny ? S_FAULT
                                                  : (leaf_chg ? S_LEAF_WB : S_DONE);
                    else if (!mem_rdata[ENT_A]) st_nx = S_DIR_WB;
                    else                    st_nx = S_TBL_RD;
                end
            end
            S_DIR_WB: begin
                if (mem_ack) st_nx = S_TBL_RD;
            end
            S_TBL_RD: begin
                if (mem_ack) begin
                    if (!ent_present || deny) st_nx = S_FAULT;
                    else                      st_nx = leaf_chg ? S_LEAF_WB : S_DONE;
                end
            end
            S_LEAF_WB: begin
                if (mem_ack) st_nx = S_DONE;
            end
            S_DONE:  st_nx = S_IDLE;
            S_FAULT: st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // request capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q        <= '0;
            wr_q        <= 1'b0;
            usr_q       <= 1'b0;
            dir_frame_q <= '0;
            dir_us_q    <= 1'b0;
            dir_rw_q    <= 1'b0;
            wb_addr_q   <= '0;
            wb_data_q   <= '0;
            pa_q        <= '0;
            wok_q       <= 1'b0;
            xok_q       <= 1'b0;
            code_q      <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        va_q  <= req_vaddr;
                        wr_q  <= (req_acc == ACC_WRITE);
                        usr_q <= req_user;
                        if (!cfg_pg) begin
                            pa_q   <= req_vaddr;
                            wok_q  <= 1'b1;
                            xok_q  <= 1'b1;
                            code_q <= '0;
                        end
                    end
                end
                S_DIR_RD, S_TBL_RD: begin
                    if (mem_ack) begin
                        if (!in_tbl) begin
                            dir_frame_q <= mem_rdata[AW-1:OFF_W];
                            dir_us_q    <= mem_rdata[ENT_US];
                            dir_rw_q    <= mem_rdata[ENT_RW];
                            wb_addr_q   <= dir_addr;
                        end else begin
                            wb_addr_q   <= tbl_addr;
                        end
                        if (!ent_present) begin
                            code_q <= {usr_q, wr_q, 1'b0};
                            pa_q   <= '0;
                            wok_q  <= 1'b0;
                            xok_q  <= 1'b0;
                        end else if (!in_tbl && !is_big) begin
                            wb_data_q <= mem_rdata | (AW'(1) << ENT_A);
                        end else if (deny) begin
                            code_q <= {usr_q, wr_q, 1'b1};
                            pa_q   <= '0;
                            wok_q  <= 1'b0;
                            xok_q  <= 1'b0;
                        end else begin
                            wb_data_q <= leaf_new;
                            pa_q      <= in_tbl ? small_pa : big_pa;
                            wok_q     <= wr_grant;
                            xok_q     <= 1'b1;
                            code_q    <= '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // port outputs
    always_comb begin
        mem_req        = (st == S_DIR_RD) || (st == S_DIR_WB)
                      || (st == S_TBL_RD) || (st == S_LEAF_WB);
        mem_we         = (st == S_DIR_WB) || (st == S_LEAF_WB);
        mem_wdata      = wb_data_q;
        unique case (st)
            S_DIR_RD: mem_addr = dir_addr;
            S_TBL_RD: mem_addr = tbl_addr;
            default:  mem_addr = wb_addr_q;
        endcase
        busy           = (st != S_IDLE);
        done           = (st == S_DONE);
        fault          = (st == S_FAULT);
        rsp_paddr      = pa_q;
        rsp_wr_ok      = wok_q;
        rsp_exec_ok    = xok_q;
        rsp_fault_code = code_q;
    end

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    p_resp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !(done || fault));

    p_resp_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault}));

    p_wb_accessed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[ENT_A]);

    p_nopg_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && req_valid && !cfg_pg) |=> (done && !mem_req));

    p_fault_no_rights_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!rsp_wr_ok && !rsp_exec_ok));
endmodule

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic        cfg_pg = 1'b1, cfg_wp = 1'b0, cfg_pse = 1'b0;
    logic [31:0] cr3 = '0;
    logic [31:0] cfg_a20_mask = 32'hFFFF_FFFF;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, done, fault, rsp_wr_ok, rsp_exec_ok;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_fault_code;

    always #2.5 clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_user(req_user), .cfg_pg(cfg_pg), .cfg_wp(cfg_wp),
        .cfg_pse(cfg_pse), .cfg_dir_frame(cr3[31:12]), .cfg_a20_mask(cfg_a20_mask),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .fault(fault), .rsp_paddr(rsp_paddr), .rsp_wr_ok(rsp_wr_ok),
        .rsp_exec_ok(rsp_exec_ok), .rsp_fault_code(rsp_fault_code)
    );

    // bench memory with variable latency
    logic [31:0] mem [0:4095];
    logic [1:0]  lat_sel = 2'd0, lat_cnt = 2'd0;
    logic        ld_en = 1'b0;
    logic [11:0] ld_a0 = '0, ld_a1 = '0;
    logic [31:0] ld_d0 = '0, ld_d1 = '0;
    int          rd_tot = 0, wr_tot = 0;
    logic [31:0] rd_log [0:3];

    assign mem_ack   = mem_req && (lat_cnt == lat_sel);
    assign mem_rdata = mem[mem_addr[13:2]];

    always @(posedge clk) begin
        if (ld_en) begin
            mem[ld_a0] <= ld_d0;
            mem[ld_a1] <= ld_d1;
        end
        if (mem_req && !mem_ack) lat_cnt <= lat_cnt + 2'd1;
        else                     lat_cnt <= 2'd0;
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                mem[mem_addr[13:2]] <= mem_wdata;
                wr_tot <= wr_tot + 1;
            end else begin
                rd_log[rd_tot[1:0]] <= mem_addr;
                rd_tot <= rd_tot + 1;
            end
        end
    end

    int n_chk = 0, n_err = 0, n_walk = 0;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                        input logic [31:0] pde, input logic [31:0] pte);
        logic [31:0] dir_a, tbl_a, e_pa, e_pde, e_pte, n_pde, n_pte;
        logic        wr, e_fault, e_wok, u, rw, den;
        logic [2:0]  e_code;
        int          e_rd, e_wr, rd0, wr0, t;
        wr      = (acc == 2'b01);
        dir_a   = ((cr3 & 32'hFFFF_F000) + {20'b0, va[31:22], 2'b00}) & cfg_a20_mask;
        tbl_a   = ((pde & 32'hFFFF_F000) + {20'b0, va[21:12], 2'b00}) & cfg_a20_mask;
        e_fault = 1'b0; e_code = 3'b000; e_pa = 32'h0; e_wok = 1'b0;
        e_pde   = pde; e_pte = pte; e_rd = 0; e_wr = 0;
        if (!cfg_pg) begin
            e_pa = va; e_wok = 1'b1;
        end else if (!pde[0]) begin
            e_rd = 1; e_fault = 1'b1; e_code = {usr, wr, 1'b0};
        end else if (pde[7] && cfg_pse) begin
            e_rd = 1; u = pde[2]; rw = pde[1];
            den = usr ? (!u || (wr && !rw)) : (wr && !rw && cfg_wp);
            if (den) begin
                e_fault = 1'b1; e_code = {usr, wr, 1'b1};
            end else begin
                n_pde = pde | 32'h20 | (wr ? 32'h40 : 32'h0);
                e_wr  = (n_pde != pde) ? 1 : 0;
                e_pde = n_pde;
                e_pa  = {pde[31:22] & cfg_a20_mask[31:22], va[21:0]};
                e_wok = n_pde[6] && (usr ? rw : (rw || !cfg_wp));
            end
        end else begin
            e_rd  = 2;
            e_pde = pde | 32'h20;
            e_wr  = (e_pde != pde) ? 1 : 0;
            if (!pte[0]) begin
                e_fault = 1'b1; e_code = {usr, wr, 1'b0};
            end else begin
                u = pde[2] & pte[2]; rw = pde[1] & pte[1];
                den = usr ? (!u || (wr && !rw)) : (wr && !rw && cfg_wp);
                if (den) begin
                    e_fault = 1'b1; e_code = {usr, wr, 1'b1};
                end else begin
                    n_pte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
                    e_wr  = e_wr + ((n_pte != pte) ? 1 : 0);
                    e_pte = n_pte;
                    e_pa  = {pte[31:12] & cfg_a20_mask[31:12], va[11:0]};
                    e_wok = n_pte[6] && (usr ? rw : (rw || !cfg_wp));
                end
            end
        end
        // preload entries
        @(negedge clk);
        ld_en = 1'b1; ld_a0 = dir_a[13:2]; ld_d0 = pde; ld_a1 = tbl_a[13:2]; ld_d1 = pte;
        lat_sel = 2'(n_walk % 3);
        @(negedge clk);
        ld_en = 1'b0;
        rd0 = rd_tot; wr0 = wr_tot;
        req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!(done || fault) && t < 40) begin
            @(negedge clk);
            t++;
        end
        n_walk++;
        if (t >= 40) begin
            chk("R12 walk finished", 32'h0, 32'h1);
            return;
        end
        chk("R5/R6/R7/R8 fault flag", {31'b0, fault}, {31'b0, e_fault});
        chk("R1/R12 done flag", {31'b0, done}, {31'b0, !e_fault});
        if (e_fault) begin
            chk("R7/R8 fault code", {29'b0, rsp_fault_code}, {29'b0, e_code});
        end else begin
            chk("R1/R3/R4/R11 paddr", rsp_paddr, e_pa);
            chk("R10 write right", {31'b0, rsp_wr_ok}, {31'b0, e_wok});
            chk("R10 exec right", {31'b0, rsp_exec_ok}, 32'h1);
        end
        @(negedge clk);
        chk("R1/R3/R4 read count", rd_tot - rd0, e_rd);
        chk("R9 write count", wr_tot - wr0, e_wr);
        if (e_rd >= 1) chk("R2/R11 dir entry addr", rd_log[rd0[1:0]], dir_a);
        if (e_rd >= 2) chk("R4/R11 table entry addr", rd_log[2'(rd0 + 1)], tbl_a);
        chk("R9 dir entry in memory", mem[dir_a[13:2]], e_pde);
        if (dir_a[13:2] != tbl_a[13:2])
            chk("R9 table entry in memory", mem[tbl_a[13:2]], e_pte);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] va, pde, pte;
        int vk;
        vk = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset done", {31'b0, done}, 32'h0);
        chk("R12 reset fault", {31'b0, fault}, 32'h0);
        chk("R12 reset mem_req", {31'b0, mem_req}, 32'h0);
        chk("R12 reset busy", {31'b0, busy}, 32'h0);

        // R1: paging off
        cfg_pg = 1'b0;
        for (int a = 0; a < 3; a++)
            walk(32'hDEAD_B000 ^ (a * 32'h0137_5A5B), 2'(a), a[0], 32'h0, 32'h0);
        cfg_pg = 1'b1;

        // directory-flag sweep (R3, R5, R6, R7, R8, R9, R10)
        cr3 = 32'h0;
        for (int f = 0; f < 64; f++)
            for (int c = 0; c < 24; c++) begin
                cfg_pse = c[0]; cfg_wp = c[1];
                pde = 32'h0C00_2000 | {24'b0, f[5], f[4], f[3], 2'b00, f[2], f[1], f[0]};
                va  = 32'h0040_3ABC + vk * 32'h0041_3013;
                vk++;
                walk(va, 2'(c / 8), c[2], pde, 32'h1234_5067);
            end

        // table-flag sweep with directory rights (R4, R5, R6, R9, R10)
        cr3 = 32'h0000_1000;
        for (int d = 0; d < 4; d++)
            for (int f = 0; f < 32; f++)
                for (int c = 0; c < 12; c++) begin
                    cfg_pse = 1'b1; cfg_wp = c[0];
                    pde = 32'h0C00_2001 | {29'b0, d[1], d[0], 1'b0};
                    pte = 32'h1234_5000 | {25'b0, f[4], f[3], 2'b00, f[2], f[1], f[0]};
                    va  = 32'h0123_4567 + vk * 32'h0041_3013;
                    vk++;
                    walk(va, 2'(c / 4), c[1], pde, pte);
                end

        // R11: mask on entry address and frame
        cfg_a20_mask = 32'hFFEF_FFFF;
        cr3 = 32'h0010_0000;
        cfg_pse = 1'b1; cfg_wp = 1'b1;
        walk(32'h0040_3ABC, 2'b01, 1'b1, 32'h0010_2007, 32'h1234_5007);
        walk(32'h0040_3ABC, 2'b00, 1'b0, 32'h0010_2027, 32'h0FF0_0067);
        walk(32'h0C13_5ABC, 2'b10, 1'b0, 32'h0030_0087, 32'h0);
        cfg_a20_mask = 32'hFFFF_FFFF;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule